// File: doc/BRIEF.md
# SIMT Warp Issue Sequencer

This block keeps a set of resident warps, each a group of threads that execute one common instruction, and streams them onto a narrower row of execution lanes. When the lane row is free, it picks one ready warp and captures that warp's program counter and per-thread active mask. It then drives the warp's threads onto the lanes one slice at a time, over as many consecutive cycles as the warp width divided by the lane count. With the defaults that is 32 threads over 8 lanes in 4 cycles, chosen from among 24 warp contexts.

Warp choice is fine-grained. A new warp can be picked at every instruction boundary, and the order rotates among the warps that are ready. Threads whose mask bit is clear keep their slot in the slice, but their lane-valid output stays low. In the final slice the block raises a one-cycle pulse on the issuing warp's bit of a per-warp vector, so that logic outside can move that warp's program counter forward. Execution units and register storage sit outside this block.

Top module: `simt_issue_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every lane-valid output and every issued-pulse bit is low.
- R2: An instruction that has been picked occupies exactly SLICES (default 4) consecutive cycles, slice 0 first and slice SLICES-1 last.
- R3: In slice k, the thread-index output of lane j is k*NUM_LANES + j. Each index is TID_W bits wide and is packed at bit offset j*TID_W of the lane index bus.
- R4: In slice k, lane j is valid exactly when bit k*NUM_LANES + j of the captured active mask is 1. Bit t of warp w's mask sits at bit w*WARP_SIZE + t of the mask input bus.
- R5: If no warp is ready at an instruction boundary, every lane-valid output is low in the following cycle and no issued bit is set.
- R6: At a boundary the block picks the first ready warp found by searching upward, with wrap-around, from the warp after the last one picked. After reset the search starts at warp 0. Readiness is sampled only at a boundary.
- R7: The warp-id and program-counter outputs hold the values captured at the pick for all slices of the instruction. Changes on the pc input (warp w at bit offset w*PC_W) or on the mask input during an instruction have no effect on that instruction.
- R8: Dropping or raising ready flags while an instruction is in its slices neither aborts nor changes that instruction.
- R9: Bit w of the issued vector is high only in the final slice of an instruction from warp w, and at most one bit is high in any cycle.
- R10: If a warp is ready at the boundary, the next instruction starts in the cycle right after the final slice, with no idle cycle between.
- R11: A warp whose active mask is all zero still occupies its SLICES cycles with every lane low, and still produces its issued pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warp_ready_i | input | NUM_WARPS | Per-warp ready flag |
| warp_pc_i | input | NUM_WARPS*PC_W | Per-warp program counter, warp w at bit offset w*PC_W |
| warp_mask_i | input | NUM_WARPS*WARP_SIZE | Per-warp active mask, warp w at bit offset w*WARP_SIZE |
| lane_valid_o | output | NUM_LANES | Per-lane thread-valid |
| lane_tid_o | output | NUM_LANES*TID_W | Per-lane thread index |
| issue_wid_o | output | WID_W | Warp being issued |
| issue_pc_o | output | PC_W | Program counter of the warp being issued |
| warp_issued_o | output | NUM_WARPS | One-cycle pulse in the final slice of warp w |

## Verification
The bench goes after the rotation pointer's wrap from the top warp back to warp 0, and after sparse ready patterns. A picker that restarted at warp 0 each time, or that did not wrap, would starve the higher warps or issue them out of order. Ready flags, program counters and masks are changed at random in the middle of instructions, which would expose a design that samples them outside the boundary as a torn warp id, a wrong pc or a changed lane pattern. A lone ready warp with an all-zero mask checks for back-to-back issue with no bubble and for a pulse even when no lane is valid. A design that skipped empty warps or inserted an idle cycle would miss the pulse or shift every following slice.

// File: rtl/simt_seq_pkg.sv
package simt_seq_pkg;
   localparam int DEF_NUM_WARPS = 24;
   localparam int DEF_WARP_SIZE = 32;
   localparam int DEF_NUM_LANES = 8;
   localparam int DEF_PC_W      = 32;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/simt_rr_pick.sv
module simt_rr_pick #(
   parameter int NUM_WARPS = simt_seq_pkg::DEF_NUM_WARPS,
   localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_WARPS-1:0] ready_i,
   input  logic                 take_i,
   output logic                 grant_valid_o,
   output logic [WID_W-1:0]     grant_id_o
);
   logic [WID_W-1:0] last_q;
   logic [WID_W:0]   cand;

   // Search upward from the warp after the last one picked, wrapping past the top.
   always_comb begin
      grant_valid_o = 1'b0;
      grant_id_o    = '0;
      cand          = '0;
      for (int i = 0; i < NUM_WARPS; i++) begin
         cand = {1'b0, last_q} + (WID_W+1)'(i) + (WID_W+1)'(1);
         if (cand >= (WID_W+1)'(NUM_WARPS))
            cand = cand - (WID_W+1)'(NUM_WARPS);
         if (!grant_valid_o && ready_i[cand[WID_W-1:0]]) begin
            grant_valid_o = 1'b1;
            grant_id_o    = cand[WID_W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      last_q <= WID_W'(NUM_WARPS - 1);
      else if (take_i && grant_valid_o) last_q <= grant_id_o;
   end

   a_r6_grant_is_ready: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid_o |-> ready_i[grant_id_o]);
   a_r6_grant_when_any: assert property (@(posedge clk) disable iff (!rst_n)
      (|ready_i) |-> grant_valid_o);
endmodule

// File: rtl/simt_ctx_latch.sv
module simt_ctx_latch #(
   parameter int NUM_WARPS = simt_seq_pkg::DEF_NUM_WARPS,
   parameter int WARP_SIZE = simt_seq_pkg::DEF_WARP_SIZE,
   parameter int NUM_LANES = simt_seq_pkg::DEF_NUM_LANES,
   parameter int PC_W      = simt_seq_pkg::DEF_PC_W,
   localparam int SLICES   = WARP_SIZE / NUM_LANES,
   localparam int SLICE_W  = (SLICES > 1) ? $clog2(SLICES) : 1,
   localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 grant_valid_i,
   input  logic [WID_W-1:0]     grant_id_i,
   input  logic [PC_W-1:0]      grant_pc_i,
   input  logic [WARP_SIZE-1:0] grant_mask_i,
   output logic                 boundary_o,
   output logic                 busy_o,
   output logic                 last_o,
   output logic [SLICE_W-1:0]   slice_o,
   output logic [WID_W-1:0]     wid_o,
   output logic [PC_W-1:0]      pc_o,
   output logic [WARP_SIZE-1:0] mask_o
);
   logic                 busy_q;
   logic [SLICE_W-1:0]   slice_q;
   logic [WID_W-1:0]     wid_q;
   logic [PC_W-1:0]      pc_q;
   logic [WARP_SIZE-1:0] mask_q;

   assign last_o     = busy_q && (slice_q == SLICE_W'(SLICES - 1));
   assign boundary_o = !busy_q || last_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         slice_q <= '0;
      end else if (boundary_o) begin
         busy_q  <= grant_valid_i;
         slice_q <= '0;
      end else begin
         slice_q <= slice_q + SLICE_W'(1);
      end
   end

   // Context is captured only when a new instruction begins.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wid_q  <= '0;
         pc_q   <= '0;
         mask_q <= '0;
      end else if (boundary_o && grant_valid_i) begin
         wid_q  <= grant_id_i;
         pc_q   <= grant_pc_i;
         mask_q <= grant_mask_i;
      end
   end

   assign busy_o  = busy_q;
   assign slice_o = slice_q;
   assign wid_o   = wid_q;
   assign pc_o    = pc_q;
   assign mask_o  = mask_q;

   a_r2_slice_step: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !last_o) |=> (busy_q && (slice_q == SLICE_W'($past(slice_q) + 1'b1))));
   a_r7_ctx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !last_o) |=> ($stable(wid_q) && $stable(pc_q) && $stable(mask_q)));
endmodule

// File: rtl/simt_lane_slicer.sv
module simt_lane_slicer #(
   parameter int WARP_SIZE = simt_seq_pkg::DEF_WARP_SIZE,
   parameter int NUM_LANES = simt_seq_pkg::DEF_NUM_LANES,
   localparam int SLICES   = WARP_SIZE / NUM_LANES,
   localparam int SLICE_W  = (SLICES > 1) ? $clog2(SLICES) : 1,
   localparam int LANE_W   = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
   localparam int TID_W    = SLICE_W + LANE_W
) (
   input  logic                       busy_i,
   input  logic [SLICE_W-1:0]         slice_i,
   input  logic [WARP_SIZE-1:0]       mask_i,
   output logic [NUM_LANES-1:0]       lane_valid_o,
   output logic [NUM_LANES*TID_W-1:0] lane_tid_o
);
   for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
      logic [TID_W-1:0] tid;
      assign tid                        = {slice_i, LANE_W'(j)};
      assign lane_tid_o[j*TID_W +: TID_W] = tid;
      assign lane_valid_o[j]            = busy_i & mask_i[tid];
   end
endmodule

// File: rtl/simt_issue_seq.sv
module simt_issue_seq #(
   parameter int NUM_WARPS = simt_seq_pkg::DEF_NUM_WARPS,
   parameter int WARP_SIZE = simt_seq_pkg::DEF_WARP_SIZE,
   parameter int NUM_LANES = simt_seq_pkg::DEF_NUM_LANES,
   parameter int PC_W      = simt_seq_pkg::DEF_PC_W,
   localparam int SLICES   = WARP_SIZE / NUM_LANES,
   localparam int SLICE_W  = (SLICES > 1) ? $clog2(SLICES) : 1,
   localparam int LANE_W   = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
   localparam int TID_W    = SLICE_W + LANE_W,
   localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_WARPS-1:0]           warp_ready_i,
   input  logic [NUM_WARPS*PC_W-1:0]      warp_pc_i,
   input  logic [NUM_WARPS*WARP_SIZE-1:0] warp_mask_i,
   output logic [NUM_LANES-1:0]           lane_valid_o,
   output logic [NUM_LANES*TID_W-1:0]     lane_tid_o,
   output logic [WID_W-1:0]               issue_wid_o,
   output logic [PC_W-1:0]                issue_pc_o,
   output logic [NUM_WARPS-1:0]           warp_issued_o
);
   // Elaboration-time parameter checks.
   if (!simt_seq_pkg::is_pow2(NUM_LANES) || NUM_LANES < 2) begin : g_bad_lanes
      $error("NUM_LANES must be a power of two, at least 2");
   end
   if (!simt_seq_pkg::is_pow2(WARP_SIZE) || WARP_SIZE < 2 * NUM_LANES) begin : g_bad_warp
      $error("WARP_SIZE must be a power of two, at least twice NUM_LANES");
   end
   if (NUM_WARPS < 2) begin : g_bad_warps
      $error("NUM_WARPS must be at least 2");
   end

   logic                 grant_valid;
   logic [WID_W-1:0]     grant_id;
   logic [PC_W-1:0]      sel_pc;
   logic [WARP_SIZE-1:0] sel_mask;
   logic                 boundary, busy, last;
   logic [SLICE_W-1:0]   slice;
   logic [WARP_SIZE-1:0] cur_mask;

   simt_rr_pick #(.NUM_WARPS(NUM_WARPS)) u_pick (
      .clk          (clk),
      .rst_n        (rst_n),
      .ready_i      (warp_ready_i),
      .take_i       (boundary),
      .grant_valid_o(grant_valid),
      .grant_id_o   (grant_id)
   );

   // Route the granted warp's context out of the flattened buses.
   always_comb begin
      sel_pc   = '0;
      sel_mask = '0;
      for (int w = 0; w < NUM_WARPS; w++) begin
         if (grant_id == WID_W'(w)) begin
            sel_pc   = warp_pc_i[w*PC_W +: PC_W];
            sel_mask = warp_mask_i[w*WARP_SIZE +: WARP_SIZE];
         end
      end
   end

   simt_ctx_latch #(
      .NUM_WARPS(NUM_WARPS), .WARP_SIZE(WARP_SIZE),
      .NUM_LANES(NUM_LANES), .PC_W(PC_W)
   ) u_ctx (
      .clk          (clk),
      .rst_n        (rst_n),
      .grant_valid_i(grant_valid),
      .grant_id_i   (grant_id),
      .grant_pc_i   (sel_pc),
      .grant_mask_i (sel_mask),
      .boundary_o   (boundary),
      .busy_o       (busy),
      .last_o       (last),
      .slice_o      (slice),
      .wid_o        (issue_wid_o),
      .pc_o         (issue_pc_o),
      .mask_o       (cur_mask)
   );

   simt_lane_slicer #(.WARP_SIZE(WARP_SIZE), .NUM_LANES(NUM_LANES)) u_slicer (
      .busy_i      (busy),
      .slice_i     (slice),
      .mask_i      (cur_mask),
      .lane_valid_o(lane_valid_o),
      .lane_tid_o  (lane_tid_o)
   );

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_issued
      assign warp_issued_o[w] = last && (issue_wid_o == WID_W'(w));
   end

   a_r9_issue_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(warp_issued_o));
   a_r10_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
      ((|warp_issued_o) && (|warp_ready_i)) |=> (busy && slice == '0));
   a_r5_idle_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && !(|warp_ready_i)) |=> (lane_valid_o == '0 && warp_issued_o == '0));
endmodule

// File: tb/simt_issue_seq_tb.sv
module simt_issue_seq_tb;
   localparam int NW = 24, WS = 32, NL = 8, PW = 32;
   localparam int SL = WS / NL;
   localparam int TW = 5, WW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [NW-1:0]    ready_a = '0;
   logic [PW-1:0]    pc_a   [NW];
   logic [WS-1:0]    mask_a [NW];
   logic [NW*PW-1:0] pc_flat;
   logic [NW*WS-1:0] mask_flat;
   logic [NL-1:0]    lane_valid;
   logic [NL*TW-1:0] lane_tid;
   logic [WW-1:0]    wid;
   logic [PW-1:0]    pc;
   logic [NW-1:0]    issued;

   always_comb begin
      for (int w = 0; w < NW; w++) begin
         pc_flat[w*PW +: PW]   = pc_a[w];
         mask_flat[w*WS +: WS] = mask_a[w];
      end
   end

   simt_issue_seq #(.NUM_WARPS(NW), .WARP_SIZE(WS), .NUM_LANES(NL), .PC_W(PW)) u_dut (
      .clk(clk), .rst_n(rst_n), .warp_ready_i(ready_a), .warp_pc_i(pc_flat),
      .warp_mask_i(mask_flat), .lane_valid_o(lane_valid), .lane_tid_o(lane_tid),
      .issue_wid_o(wid), .issue_pc_o(pc), .warp_issued_o(issued));

   // Behavioural reference model.
   int          m_busy = 0, m_slice = 0, m_wid = 0, m_last = NW - 1;
   logic [PW-1:0] m_pc = '0;
   logic [WS-1:0] m_mask = '0;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_slice = 0; m_last = NW - 1;
      end else if (m_busy == 0 || m_slice == SL - 1) begin
         int pick;
         pick = -1;
         for (int i = 1; i <= NW; i++)
            if (pick < 0 && ready_a[(m_last + i) % NW]) pick = (m_last + i) % NW;
         if (pick >= 0) begin
            m_busy = 1; m_slice = 0; m_wid = pick; m_last = pick;
            m_pc = pc_a[pick]; m_mask = mask_a[pick];
         end else m_busy = 0;
      end else m_slice++;
   end

   int vectors = 0, miscompares = 0;
   bit done = 0;
   bit auto_adv = 1;

   task automatic cmp(input string req, input string what, input longint act, input longint exp);
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // One cycle: compare at the falling edge, then advance pcs of issued warps.
   task automatic step();
      logic [NL-1:0] ev;
      logic [NW-1:0] ei;
      @(negedge clk);
      vectors++;
      for (int j = 0; j < NL; j++) ev[j] = (m_busy != 0) && m_mask[m_slice*NL + j];
      ei = (m_busy != 0 && m_slice == SL - 1) ? (NW'(1) << m_wid) : '0;
      cmp("R4", "lane_valid", lane_valid, ev);   // R2 R5 R8 R11 also seen here
      cmp("R9", "issued", issued, ei);
      if (m_busy != 0) begin
         for (int j = 0; j < NL; j++)
            cmp("R3", "lane_tid", lane_tid[j*TW +: TW], m_slice*NL + j);
         cmp("R6", "warp_id", wid, m_wid);
         cmp("R7", "pc", pc, m_pc);
      end
      if (auto_adv)
         for (int w = 0; w < NW; w++) if (issued[w]) pc_a[w] = pc_a[w] + 4;
   endtask

   initial begin
      for (int w = 0; w < NW; w++) begin
         pc_a[w]   = 32'h1000 * (w + 1);
         mask_a[w] = 32'hC3A5_0F96 ^ (32'h0101_0101 * w) ^ (32'h1 << w);
      end
      mask_a[0] = '1;
      mask_a[5] = '0;
      // R1: reset state
      repeat (3) begin
         @(negedge clk);
         vectors++;
         cmp("R1", "lane_valid in reset", lane_valid, 0);
         cmp("R1", "issued in reset", issued, 0);
      end
      rst_n = 1'b1;
      step();
      vectors++;
      cmp("R1", "lane_valid after reset", lane_valid, 0);
      // R6 R10: all warps ready, full rotation and wrap back to warp 0
      ready_a = '1;
      repeat (NW * SL * 2 + 3) step();
      // R6: sparse ready set
      ready_a = '0; ready_a[3] = 1'b1; ready_a[17] = 1'b1; ready_a[23] = 1'b1;
      repeat (40) step();
      // R11 R10: lone ready warp with empty mask, back to back
      ready_a = '0; ready_a[5] = 1'b1;
      repeat (20) step();
      // R5: nothing ready
      ready_a = '0;
      repeat (12) step();
      // R7 R8: inputs churn mid-instruction
      auto_adv = 0;
      repeat (600) begin
         ready_a = NW'($urandom) & NW'($urandom);
         for (int k = 0; k < 3; k++) begin
            int w;
            w = $urandom_range(NW - 1);
            pc_a[w]   = $urandom;
            mask_a[w] = $urandom;
         end
         step();
      end
      // R5 then R6 resume
      ready_a = '0;
      repeat (10) step();
      ready_a[22] = 1'b1; ready_a[1] = 1'b1;
      repeat (30) step();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired, run did not complete");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule